// File: doc/BRIEF.md
# I2C Line Self-Test Sequencer

This block checks, before any transfer is attempted, that the clock and data wires of a two-wire open-drain bus can be pulled low and released. After a one-cycle `start` pulse it first confirms that both wires are high at rest. It then works through four steps: data pulled, data released, clock pulled, clock released. At every step both wires are read back, so it checks that the line being exercised follows its drive and that the other line has not moved with it.

Every step holds its drive pattern for `SETTLE` cycles and samples the wires in the last cycle of that window. When the clock is released, a target device may hold it low for a while. The sequencer waits for it to rise, for up to `STRETCH_MAX` cycles. The first mismatch ends the test. The sequencer then releases the data line, releases the clock line, and reports a distinct error code. A test with no mismatch reports a pass. When the clock wire has no read-back path (`SCL_SENSE = 0`), the level the clock should have at each step is used in place of the read value, so only the data wire is really tested.

Top module: `i2c_line_selftest`

## Requirements
- R1: After reset the block is idle: no line is pulled, and `busy`, `done`, `pass` and `err_code` are all 0.
- R2: A run holds five windows of `SETTLE` cycles each, in this order: nothing pulled, data pulled, nothing pulled, clock pulled, nothing pulled. The block never pulls both lines in the same cycle.
- R3: If either line reads low in the first (rest) window, the error code is 1 (bus occupied).
- R4: If the data line reads high while it is pulled, the error code is 2.
- R5: If the data line reads low after it has been released, the error code is 3.
- R6: If the clock line reads high while it is pulled, the error code is 4.
- R7: After the clock is released, each cycle in which it reads low restarts the window. If it is still low after `STRETCH_MAX` such cycles, the error code is 5. A shorter hold only delays completion.
- R8: Within one window the exercised line is judged first. If it is correct but the other line is not at its expected level, the error code is 6.
- R9: On a failure the block releases the data line for `SETTLE` cycles while keeping the clock at its current drive. It then releases the clock for `SETTLE` cycles, and only then signals completion.
- R10: `done` is a one-cycle pulse. For a clean run it falls 5·`SETTLE`+1 cycles after the start edge (plus any clock hold) and carries `pass`=1 and `err_code`=0. `pass` and `err_code` stay unchanged until the next accepted start.
- R11: A `start` pulse while `busy` is high is ignored and does not change the run in progress.
- R12: With `SCL_SENSE`=0 the clock input is ignored. A bus with a healthy data line passes even when the clock input is stuck low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a test (idle only) |
| scl_in | input | 1 | Synchronised level of the clock wire |
| sda_in | input | 1 | Synchronised level of the data wire |
| scl_low | output | 1 | 1 = pull the clock wire low |
| sda_low | output | 1 | 1 = pull the data wire low |
| busy | output | 1 | Test in progress (including the done cycle) |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Last test passed |
| err_code | output | 3 | 0 none, 1 occupied, 2 data stuck high, 3 data stuck low, 4 clock stuck high, 5 clock stuck low, 6 other line wrong |

## Verification
The drives change in the cycle right after each window's sampling edge, and the verdict lands on the same edge. A clean run therefore ends with `done` 5·`SETTLE`+1 cycles after the start edge, and a failure in window k ends it (k+2)·`SETTLE`+1 cycles after the start edge. The bench keeps a behavioural model with its own copy of the faulty bus, steps it on the same edge as the design, and compares drives, `busy`, `done`, `pass` and `err_code` at every falling edge, so each output is checked in the exact cycle it is due. Fault scenarios (stuck, latching, shorted and slow-rising lines) also have their final codes checked against hand-derived values.

// File: rtl/i2c_line_selftest.sv
module i2c_line_selftest #(
  parameter int SETTLE      = 4,
  parameter int STRETCH_MAX = 16,
  parameter bit SCL_SENSE   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic [2:0] err_code
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam int WW = $clog2(STRETCH_MAX + 1);

  localparam logic [2:0] E_NONE   = 3'd0;
  localparam logic [2:0] E_BUSY   = 3'd1;
  localparam logic [2:0] E_SDA_HI = 3'd2;
  localparam logic [2:0] E_SDA_LO = 3'd3;
  localparam logic [2:0] E_SCL_HI = 3'd4;
  localparam logic [2:0] E_SCL_LO = 3'd5;
  localparam logic [2:0] E_OTHER  = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_REST, S_DPULL, S_DFREE, S_CPULL, S_CFREE, S_REL_D, S_REL_C, S_DONE
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic          hold_c;
  logic [2:0]    chk;

  wire scl_v      = SCL_SENSE ? scl_in : (st != S_CPULL);
  wire settle_end = (cnt == CW'(SETTLE - 1));
  wire stalled    = (st == S_CFREE) && !scl_v;

  assign sda_low = (st == S_DPULL);
  assign scl_low = (st == S_CPULL) || (st == S_REL_D && hold_c);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);

  always_comb begin
    chk = E_NONE;
    case (st)
      S_REST:  if (!sda_in || !scl_v) chk = E_BUSY;
      S_DPULL: if (sda_in) chk = E_SDA_HI; else if (!scl_v) chk = E_OTHER;
      S_DFREE: if (!sda_in) chk = E_SDA_LO; else if (!scl_v) chk = E_OTHER;
      S_CPULL: if (scl_v) chk = E_SCL_HI; else if (!sda_in) chk = E_OTHER;
      S_CFREE: if (!scl_v) chk = E_SCL_LO; else if (!sda_in) chk = E_OTHER;
      default: chk = E_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      wcnt     <= '0;
      hold_c   <= 1'b0;
      pass     <= 1'b0;
      err_code <= E_NONE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_REST;
          cnt      <= '0;
          wcnt     <= '0;
          hold_c   <= 1'b0;
          pass     <= 1'b0;
          err_code <= E_NONE;
        end
        S_REST, S_DPULL, S_DFREE, S_CPULL, S_CFREE: begin
          if (stalled) begin
            cnt <= '0;
            if (wcnt == WW'(STRETCH_MAX - 1)) begin
              err_code <= E_SCL_LO;
              st       <= S_REL_D;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end else if (settle_end) begin
            cnt <= '0;
            if (chk != E_NONE) begin
              err_code <= chk;
              hold_c   <= (st == S_CPULL);
              st       <= S_REL_D;
            end else if (st == S_CFREE) begin
              pass <= 1'b1;
              st   <= S_DONE;
            end else begin
              st <= state_t'(st + 4'd1);
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REL_D: if (settle_end) begin
          cnt <= '0;
          st  <= S_REL_C;
        end else cnt <= cnt + 1'b1;
        S_REL_C: if (settle_end) begin
          cnt <= '0;
          st  <= S_DONE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_low && scl_low));
  a_r9_data_freed_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_low) |-> !sda_low);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (err_code == E_NONE));
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err_code) && $stable(pass)));
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
  a_r7_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CFREE) |-> (wcnt < WW'(STRETCH_MAX)));
endmodule

// File: tb/i2c_line_selftest_test.sv
module i2c_line_selftest_test;
  localparam int SET = 4;
  localparam int SMAX = 12;
  localparam int KSTR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clr = 1'b0;
  int   fmode = 0;
  int   total = 0;
  int   bad = 0;

  always #10 clk = ~clk;

  logic scl_low, sda_low, busy, done, pass;
  logic [2:0] err_code;
  logic scl_in, sda_in;

  logic scl_low2, sda_low2, busy2, done2, pass2;
  logic [2:0] err2;

  i2c_line_selftest #(.SETTLE(SET), .STRETCH_MAX(SMAX), .SCL_SENSE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .scl_in(scl_in), .sda_in(sda_in),
    .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .done(done),
    .pass(pass), .err_code(err_code));

  i2c_line_selftest #(.SETTLE(SET), .STRETCH_MAX(SMAX), .SCL_SENSE(1'b0)) uut_nosense (
    .clk(clk), .rst_n(rst_n), .start(start), .scl_in(1'b0), .sda_in(~sda_low2),
    .scl_low(scl_low2), .sda_low(sda_low2), .busy(busy2), .done(done2),
    .pass(pass2), .err_code(err2));

  // faulty bus: {scl, sda}
  function automatic logic [1:0] bus(input int mode, input logic dsda, input logic dscl,
                                     input logic lsda, input logic lscl, input int rc);
    logic s, c;
    s = !dsda;
    c = !dscl;
    case (mode)
      1: s = 1'b0;
      2: s = 1'b1;
      3: if (lsda) s = 1'b0;
      4: c = 1'b1;
      5: if (lscl) c = 1'b0;
      7: if (rc < KSTR) c = 1'b0;
      default: ;
    endcase
    if (mode == 6) begin
      s = s & c;
      c = s;
    end
    return {c, s};
  endfunction

  logic u_lsda = 1'b0, u_lscl = 1'b0, m_lsda = 1'b0, m_lscl = 1'b0;
  int   u_rc = 100, m_rc = 100;

  // reference model state
  int   m_step = -1;
  int   m_t = 0;
  int   m_w = 0;
  logic m_hold = 1'b0;
  logic m_pass = 1'b0;
  logic [2:0] m_err = 3'd0;

  wire m_dsda = (m_step == 1);
  wire m_dscl = (m_step == 3) || (m_step == 5 && m_hold);
  wire [1:0] u_bus = bus(fmode, sda_low, scl_low, u_lsda, u_lscl, u_rc);
  wire [1:0] m_bus = bus(fmode, m_dsda, m_dscl, m_lsda, m_lscl, m_rc);
  assign sda_in = u_bus[0];
  assign scl_in = u_bus[1];

  always @(posedge clk) begin
    if (clr) begin
      u_lsda <= 1'b0; u_lscl <= 1'b0; u_rc <= 100;
      m_lsda <= 1'b0; m_lscl <= 1'b0; m_rc <= 100;
    end else begin
      u_lsda <= u_lsda | (fmode == 3 && sda_low);
      u_lscl <= u_lscl | (fmode == 5 && scl_low);
      u_rc   <= scl_low ? 0 : (u_rc < 100 ? u_rc + 1 : u_rc);
      m_lsda <= m_lsda | (fmode == 3 && m_dsda);
      m_lscl <= m_lscl | (fmode == 5 && m_dscl);
      m_rc   <= m_dscl ? 0 : (m_rc < 100 ? m_rc + 1 : m_rc);
    end
  end

  function automatic logic [2:0] verdict(input int step, input logic s, input logic c);
    case (step)
      0: return (!s || !c) ? 3'd1 : 3'd0;
      1: return s ? 3'd2 : (!c ? 3'd6 : 3'd0);
      2: return !s ? 3'd3 : (!c ? 3'd6 : 3'd0);
      3: return c ? 3'd4 : (!s ? 3'd6 : 3'd0);
      default: return !c ? 3'd5 : (!s ? 3'd6 : 3'd0);
    endcase
  endfunction

  always @(posedge clk) begin
    logic [2:0] v;
    if (!rst_n) begin
      m_step <= -1; m_t <= 0; m_w <= 0; m_hold <= 1'b0; m_pass <= 1'b0; m_err <= 3'd0;
    end else if (m_step == -1) begin
      if (start) begin
        m_step <= 0; m_t <= 0; m_w <= 0; m_hold <= 1'b0; m_pass <= 1'b0; m_err <= 3'd0;
      end
    end else if (m_step <= 4) begin
      if (m_step == 4 && !m_bus[1]) begin
        m_t <= 0;
        if (m_w + 1 >= SMAX) begin
          m_err <= 3'd5; m_step <= 5;
        end else m_w <= m_w + 1;
      end else if (m_t + 1 == SET) begin
        m_t <= 0;
        v = verdict(m_step, m_bus[0], m_bus[1]);
        if (v != 3'd0) begin
          m_err <= v; m_hold <= (m_step == 3); m_step <= 5;
        end else if (m_step == 4) begin
          m_pass <= 1'b1; m_step <= 7;
        end else m_step <= m_step + 1;
      end else m_t <= m_t + 1;
    end else if (m_step == 5 || m_step == 6) begin
      if (m_t + 1 == SET) begin
        m_t <= 0; m_step <= m_step + 1;
      end else m_t <= m_t + 1;
    end else m_step <= -1;
  end

  // per-cycle comparison (R2, R9, R10 timing)
  always @(negedge clk) begin
    logic [6:0] got, exp;
    if (rst_n) begin
      got = {sda_low, scl_low, busy, done, pass, err_code[1:0]};
      exp = {m_dsda, m_dscl, (m_step != -1), (m_step == 7), m_pass, m_err[1:0]};
      total++;
      if (got !== exp || err_code[2] !== m_err[2]) begin
        bad++;
        $display("FAIL R2/R9/R10 cycle compare: got=%b/%0d exp=%b/%0d", got, err_code, exp, m_err);
      end
    end
  end

  task automatic check(input string tag, input logic [2:0] ge, input logic gp,
                       input logic [2:0] ee, input logic ep);
    total++;
    if (ge !== ee || gp !== ep) begin
      bad++;
      $display("FAIL %s: err=%0d pass=%0b expected err=%0d pass=%0b", tag, ge, gp, ee, ep);
    end
  endtask

  task automatic run_case(input int mode, input logic [2:0] ee, input logic ep,
                          input string tag, input bit poke);
    int n;
    @(negedge clk); fmode = mode; clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk); n++;
    end
    if (n >= 500) begin
      total++; bad++;
      $display("FAIL %s: no done, got busy=%0b expected done=1", tag, busy);
    end
    check(tag, err_code, pass, ee, ep);
    if (mode == 0 && !poke) check("R12 unread clock", err2, pass2, 3'd0, 1'b1);
    repeat (2) @(negedge clk);
    check({tag, " held (R10)"}, err_code, pass, ee, ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset idle", err_code, pass | busy | done | sda_low | scl_low, 3'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", err_code, pass | busy | done | sda_low | scl_low, 3'd0, 1'b0);
    run_case(0, 3'd0, 1'b1, "R10 clean pass", 1'b0);
    run_case(1, 3'd1, 1'b0, "R3 data low at rest", 1'b0);
    run_case(2, 3'd2, 1'b0, "R4 data stuck high", 1'b0);
    run_case(3, 3'd3, 1'b0, "R5 data stuck low", 1'b0);
    run_case(4, 3'd4, 1'b0, "R6 clock stuck high", 1'b0);
    run_case(5, 3'd5, 1'b0, "R7 clock never rises", 1'b0);
    run_case(7, 3'd0, 1'b1, "R7 short hold passes", 1'b0);
    run_case(6, 3'd6, 1'b0, "R8 lines shorted", 1'b0);
    run_case(0, 3'd0, 1'b1, "R11 start while busy", 1'b1);
    run_case(4, 3'd4, 1'b0, "R9 recovery after clock fault", 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung, got busy=%0b expected finish", busy);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule